// File: doc/BRIEF.md
# Object Attribute Copy Engine

This block fills the 160-byte object attribute table of a video unit from a 256-byte-aligned page of system memory. The CPU starts it by writing a page number to a trigger register. The engine then reads one source byte per transfer step and writes it to the matching table entry. The source byte for entry k sits at address (page << 8) | k.

A running count decides when each step happens. In normal speed a step falls on every fourth clock. In double speed a step falls on every second clock. The first step only warms up and moves no data. The step after the last copy ends the transfer.

The block also sits between the CPU and the table for the window 0xFE00 to 0xFE9F. A fixed 8 clocks after a transfer starts, the CPU is shut out of that window until the transfer ends. The table itself is outside the block and has a single port with a combinational read.

Top module: `sprite_dma`

## Requirements
- R1: After reset and while no transfer runs, `dma_busy` is 0, the engine issues no source read and no table write, and CPU accesses in the window reach the table (a write drives `oam_we`; a read returns `oam_rdata`).
- R2: A write on the trigger port sets `dma_busy` on the next edge and latches `trig_data` as the source page. Every source read of that transfer carries the page in `src_addr[15:8]`.
- R3: In normal speed (`fast_mode` = 0), call the first cycle after the trigger edge cycle 0. No copy happens in cycle 0. Entry k (0 to 159) is written in cycle 4(k+1), and no engine write happens in any other cycle.
- R4: In double speed (`fast_mode` = 1), entry k is written in cycle 2(k+1). No engine write happens in cycle 0 or in odd cycles.
- R5: Each engine write puts the byte read from source offset k into table entry k. After a transfer all 160 entries equal their source bytes.
- R6: `dma_busy` stays high for exactly 645 cycles (cycles 0 to 644) in normal speed and 323 cycles in double speed.
- R7: From cycle 8 until `dma_busy` falls, a CPU read in the window returns 0xFF and a CPU write there causes no table write. This holds in both speeds.
- R8: In cycles 0 to 7 of a transfer, CPU reads and writes in the window reach the table, except in copy cycles (see R10).
- R9: A trigger write during a running transfer restarts it at cycle 0 with the new page. The full 645-cycle timing applies again, and the table ends up holding the new page.
- R10: In a copy cycle the engine owns the table port. A CPU write in that cycle is dropped, and the port carries the engine's entry and data.
- R11: CPU accesses outside 0xFE00 to 0xFE9F never write the table, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 = double-speed stepping |
| trig_we | input | 1 | CPU write strobe for the trigger register |
| trig_data | input | 8 | Source page written with the trigger |
| cpu_addr | input | 16 | CPU access address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data from the table window |
| src_addr | output | 16 | Source memory read address |
| src_rd | output | 1 | Source read strobe (copy cycles) |
| src_rdata | input | 8 | Source memory data, same cycle |
| oam_we | output | 1 | Table write enable |
| oam_addr | output | 8 | Table entry address |
| oam_wdata | output | 8 | Table write data |
| oam_rdata | input | 8 | Table read data at `oam_addr`, same cycle |
| dma_busy | output | 1 | Transfer in progress |

## Verification
A wrong step decode shows up at once: a table write lands in the wrong cycle or at the wrong entry within the first dozen cycles of a transfer. A miscounted end shows up when `dma_busy` stays high too long or drops too early.

A lockout threshold that is off by one shows up in cycle 7 or 8 as a 0xFF read that should not be there, or as a real read that should have been 0xFF. It can also appear as a stray table write. A page register that loses its value corrupts every byte that follows, and the full table comparison at the end of each transfer catches that.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // Step spacing exponents for the two speed modes.
  localparam int unsigned SHIFT_NORMAL = 2;
  localparam int unsigned SHIFT_FAST   = 1;
  localparam int unsigned CNT_XW       = 16;

  // A transfer step falls on counts whose low mode bits are all zero.
  function automatic logic step_due(input logic [CNT_XW-1:0] cnt, input logic fast);
    if (fast) return (cnt[0] == 1'b0);
    return (cnt[1:0] == 2'b00);
  endfunction

  // Step number is the count with the mode bits dropped.
  function automatic logic [CNT_XW-1:0] step_index(input logic [CNT_XW-1:0] cnt,
                                                    input logic fast);
    if (fast) return cnt >> SHIFT_FAST;
    return cnt >> SHIFT_NORMAL;
  endfunction

  // Address window test, done in 32 bits so any bus width fits.
  function automatic logic in_window(input logic [31:0] addr, input int unsigned base,
                                     input int unsigned n);
    return (addr >= base) && (addr < base + n);
  endfunction

endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int unsigned N_BYTES    = 160,
  parameter int unsigned LOCK_DELAY = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned LOW_W      = 8,
  parameter int unsigned CNT_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  output logic              busy,
  output logic [PAGE_W-1:0] page,
  output logic              step_evt,
  output logic              copy_evt,
  output logic              done_evt,
  output logic              lock_on,
  output logic [LOW_W-1:0]  copy_off
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_XW-1:0] cnt_x;
  logic [CNT_XW-1:0] idx;

  assign cnt_x    = CNT_XW'(cnt_q);
  assign idx      = step_index(cnt_x, fast);
  assign step_evt = busy && step_due(cnt_x, fast);
  assign copy_evt = step_evt && (idx != '0) && (idx <= CNT_XW'(N_BYTES));
  // Using >= keeps the end reachable even if the speed changes mid-transfer.
  assign done_evt = step_evt && (idx >= CNT_XW'(N_BYTES + 1));
  assign lock_on  = busy && (cnt_x >= CNT_XW'(LOCK_DELAY));
  assign copy_off = LOW_W'(idx - CNT_XW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      page  <= '0;
    end else if (trig_we) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      page  <= trig_page;
    end else if (busy) begin
      if (done_evt) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdma_port.sv
module sdma_port
  import sdma_pkg::*;
#(
  parameter int unsigned N_BYTES  = 160,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OAM_AW   = 8,
  parameter int unsigned OAM_BASE = 'hFE00
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lock_on,
  input  logic              copy_evt,
  input  logic [OAM_AW-1:0] copy_off,
  input  logic [DATA_W-1:0] src_rdata,
  output logic              oam_we,
  output logic [OAM_AW-1:0] oam_addr,
  output logic [DATA_W-1:0] oam_wdata,
  input  logic [DATA_W-1:0] oam_rdata,
  output logic              cpu_hit
);

  logic              cpu_open;
  logic [OAM_AW-1:0] cpu_off;

  assign cpu_hit  = in_window(32'(cpu_addr), OAM_BASE, N_BYTES);
  assign cpu_off  = OAM_AW'(cpu_addr - ADDR_W'(OAM_BASE));
  // The CPU reaches the table only when it hits the window, no lock, no copy.
  assign cpu_open = cpu_hit && !lock_on && !copy_evt;

  always_comb begin
    if (copy_evt) begin
      oam_we    = 1'b1;
      oam_addr  = copy_off;
      oam_wdata = src_rdata;
    end else begin
      oam_we    = cpu_open && cpu_wr;
      oam_addr  = cpu_off;
      oam_wdata = cpu_wdata;
    end
  end

  assign cpu_rdata = (cpu_open && cpu_rd) ? oam_rdata : {DATA_W{1'b1}};

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int unsigned N_BYTES    = 160,
  parameter int unsigned LOCK_DELAY = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned OAM_BASE   = 'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0] src_addr,
  output logic              src_rd,
  input  logic [DATA_W-1:0] src_rdata,
  output logic              oam_we,
  output logic [7:0]        oam_addr,
  output logic [DATA_W-1:0] oam_wdata,
  input  logic [DATA_W-1:0] oam_rdata,
  output logic              dma_busy
);

  localparam int unsigned LOW_W  = ADDR_W - PAGE_W;
  localparam int unsigned OAM_AW = 8;
  localparam int unsigned CNT_W  = $clog2((N_BYTES + 2) * 4) + 1;

  logic              busy;
  logic [PAGE_W-1:0] src_page;
  logic              step_evt;
  logic              copy_evt;
  logic              done_evt;
  logic              lock_on;
  logic [LOW_W-1:0]  copy_off;
  logic              cpu_hit;

  sdma_seq #(
    .N_BYTES(N_BYTES), .LOCK_DELAY(LOCK_DELAY),
    .PAGE_W(PAGE_W), .LOW_W(LOW_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fast(fast_mode),
    .trig_we(trig_we), .trig_page(trig_data),
    .busy(busy), .page(src_page), .step_evt(step_evt),
    .copy_evt(copy_evt), .done_evt(done_evt),
    .lock_on(lock_on), .copy_off(copy_off)
  );

  sdma_port #(
    .N_BYTES(N_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OAM_AW(OAM_AW), .OAM_BASE(OAM_BASE)
  ) u_port (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .lock_on(lock_on), .copy_evt(copy_evt),
    .copy_off(OAM_AW'(copy_off)), .src_rdata(src_rdata),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata),
    .oam_rdata(oam_rdata), .cpu_hit(cpu_hit)
  );

  assign src_addr = {src_page, copy_off};
  assign src_rd   = copy_evt;
  assign dma_busy = busy;

endmodule

// File: rtl/sprite_dma_checker.sv
module sprite_dma_checker #(
  parameter int unsigned PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_we,
  input logic              busy,
  input logic              copy_evt,
  input logic              done_evt,
  input logic              lock_on,
  input logic              cpu_rd,
  input logic              cpu_hit,
  input logic [7:0]        cpu_rdata,
  input logic              oam_we,
  input logic [7:0]        oam_addr,
  input logic [15:0]       src_addr,
  input logic              src_rd,
  input logic [PAGE_W-1:0] src_page
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!copy_evt && !src_rd));

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trig_we) |=> $stable(src_page));

  assert_warmup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> !copy_evt);

  assert_copy_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |-> (oam_we && src_rd && oam_addr == src_addr[7:0]));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !trig_we) |=> !busy);

  assert_lock_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_on && oam_we) |-> copy_evt);

  assert_lock_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_on && cpu_rd && cpu_hit) |-> cpu_rdata == 8'hFF);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> busy);

endmodule

bind sprite_dma sprite_dma_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .busy(busy),
  .copy_evt(copy_evt), .done_evt(done_evt), .lock_on(lock_on),
  .cpu_rd(cpu_rd), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
  .oam_we(oam_we), .oam_addr(oam_addr), .src_addr(src_addr),
  .src_rd(src_rd), .src_page(src_page)
);

// File: tb/sprite_dma_bench.sv
module sprite_dma_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_mode = 1'b0;
  logic        trig_we = 1'b0;
  logic [7:0]  trig_data = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic [15:0] src_addr;
  logic        src_rd;
  logic [7:0]  src_rdata;
  logic        oam_we;
  logic [7:0]  oam_addr;
  logic [7:0]  oam_wdata;
  logic [7:0]  oam_rdata;
  logic        dma_busy;

  int checks = 0;
  int errors = 0;
  logic [7:0] oam_m [0:159];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sprite_dma u_sprite_dma (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .trig_we(trig_we), .trig_data(trig_data),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .src_addr(src_addr), .src_rd(src_rd), .src_rdata(src_rdata),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata),
    .oam_rdata(oam_rdata), .dma_busy(dma_busy)
  );

  // Source memory content is a formula of page and offset.
  function automatic logic [7:0] srcval(input logic [7:0] pg, input logic [7:0] off);
    return (pg * 8'd29) ^ (off * 8'd5 + 8'd3);
  endfunction

  assign src_rdata = srcval(src_addr[15:8], src_addr[7:0]);
  assign oam_rdata = (oam_addr < 8'd160) ? oam_m[oam_addr] : 8'h00;

  always @(posedge clk) if (oam_we && oam_addr < 8'd160) oam_m[oam_addr] <= oam_wdata;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] pg);
    trig_we = 1'b1;
    trig_data = pg;
    @(posedge clk);
    @(negedge clk);
    trig_we = 1'b0;
  endtask

  task automatic cpu_idle();
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    check(dma_busy == 1'b0, "R1 busy after reset", dma_busy, 0);
    check(oam_we == 1'b0 && src_rd == 1'b0, "R1 no engine access", oam_we, 0);
    cpu_addr = 16'hFE10; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
    #1;
    check(oam_we == 1'b1 && oam_addr == 8'h10, "R1 idle cpu write", oam_addr, 16);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b1;
    #1;
    check(cpu_rdata == 8'h5A, "R1 idle cpu read", cpu_rdata, 'h5A);
    cpu_addr = 16'hFEA0; cpu_wr = 1'b1; cpu_rd = 1'b1;
    #1;
    check(oam_we == 1'b0, "R11 write outside window", oam_we, 0);
    check(cpu_rdata == 8'hFF, "R11 read outside window", cpu_rdata, 'hFF);
    @(negedge clk);
    cpu_idle();
  endtask

  task automatic run_and_measure(input logic [7:0] pg, input int p, input string rq,
                                 output int n);
    int bad_t = 0;
    int bad_pg = 0;
    n = 0;
    while (dma_busy && n < 2000) begin
      logic exp_copy;
      #1;
      exp_copy = (n % p == 0) && (n / p >= 1) && (n / p <= 160);
      if (oam_we !== exp_copy) bad_t++;
      if (exp_copy && oam_addr != 8'(n / p - 1)) bad_t++;
      if (exp_copy && src_addr[15:8] != pg) bad_pg++;
      @(negedge clk);
      n++;
    end
    check(bad_t == 0, rq, bad_t, 0);
    check(bad_pg == 0, "R2 source page", bad_pg, 0);
  endtask

  task automatic check_table(input logic [7:0] pg, input string rq);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < 160; k++) begin
      if (oam_m[k] != srcval(pg, 8'(k))) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    check(bad == 0, rq, first, -1);
  endtask

  task automatic test_copy(input logic fst, input logic [7:0] pg);
    int n;
    fast_mode = fst;
    start(pg);
    run_and_measure(pg, fst ? 2 : 4, fst ? "R4 step timing" : "R3 step timing", n);
    check(n == (fst ? 323 : 645), "R6 busy length", n, fst ? 323 : 645);
    check_table(pg, "R5 table contents");
  endtask

  task automatic test_lock(input logic fst, input logic [7:0] pg);
    fast_mode = fst;
    start(pg);
    for (int n = 0; n < 12; n++) begin
      cpu_idle();
      if (n == 5) begin
        cpu_addr = 16'hFE20; cpu_wdata = 8'hAA; cpu_wr = 1'b1;
        #1;
        if (!fst) check(oam_we && oam_addr == 8'h20 && oam_wdata == 8'hAA,
                        "R8 early cpu write", oam_addr, 'h20);
      end
      if (n == 7) begin
        cpu_addr = 16'hFE20; cpu_rd = 1'b1;
        #1;
        check(cpu_rdata == 8'hAA || fst, "R8 early cpu read", cpu_rdata, 'hAA);
      end
      if (n == 4 && !fst) begin
        cpu_addr = 16'hFE30; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1;
        check(oam_we && oam_addr == 8'h00 && oam_wdata == srcval(pg, 8'h00),
              "R10 copy owns port", oam_addr, 0);
      end
      if (n == 8) begin
        cpu_addr = 16'hFE20; cpu_rd = 1'b1;
        #1;
        check(cpu_rdata == 8'hFF, "R7 locked read", cpu_rdata, 'hFF);
      end
      if (n == 9) begin
        cpu_addr = 16'hFE21; cpu_wdata = 8'h33; cpu_wr = 1'b1;
        #1;
        check(oam_we == 1'b0, "R7 locked write", oam_we, 0);
      end
      @(negedge clk);
    end
    cpu_idle();
    while (dma_busy) @(negedge clk);
    cpu_addr = 16'hFE21; cpu_rd = 1'b1;
    #1;
    check(cpu_rdata == srcval(pg, 8'h21), "R7 lock released", cpu_rdata,
          srcval(pg, 8'h21));
    @(negedge clk);
    cpu_idle();
  endtask

  task automatic test_retrigger();
    int n;
    fast_mode = 1'b0;
    start(8'h41);
    repeat (100) @(negedge clk);
    start(8'hC7);
    run_and_measure(8'hC7, 4, "R9 restart timing", n);
    check(n == 645, "R9 restart length", n, 645);
    check_table(8'hC7, "R9 new page contents");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 160; k++) oam_m[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_copy(1'b0, 8'h12);
    test_copy(1'b1, 8'hA5);
    test_lock(1'b0, 8'h3C);
    test_lock(1'b1, 8'h66);
    test_retrigger();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule